// File: doc/BRIEF.md
# Write-Through Two-Way Data Cache

This block is a small level-one data cache placed between a processor load/store port and a memory master port that moves one word per handshake. Each request is looked up in up to two ways. A read miss pulls a whole four-word line from memory and hands the requested word back. Stores always go to memory. A store that hits also updates the cached word. A store that misses leaves the cache unchanged.

A two-bit state field selects one of three modes: enabled, frozen or disabled. Each line carries a lock bit, written through a diagnostic tag port, that keeps the line from being replaced. A flush pulse drops every line. Writes by other bus masters, presented on a snoop input, invalidate matching lines. Every access returns a status code and a way number, so a test can see how the result was produced.

Top module: `wt_dcache`

## Requirements
- R1: A store in enabled or frozen mode issues exactly one memory write of its address and data. A store hit (status 10) also updates the cached word. A store miss (status 11) allocates nothing, so a later load of that address misses.
- R2: A load hits only when a way at the indexed set is valid and its tag equals the address tag. A hit returns the cached word and makes no memory access. On a load miss the cache reads 4 words from memory, starting at the line base (address with bits 3:0 cleared) and rising by 4, and then returns the requested word.
- R3: The mode field `cache_mode` is decoded as follows: bit 0 = 0 means disabled, 2'b01 means frozen, 2'b11 means enabled.
- R4: In frozen mode, loads that hit and all stores behave as in enabled mode. A load miss still reads the line but allocates nothing, reports way 0, and sets `cpu_fmiss`.
- R5: In disabled mode every access makes a single memory transfer to its own address and sets `cpu_bypass`. It reports status 01 for a load and 11 for a store, with way 0.
- R6: A snoop pulse invalidates a line with the same set and tag only when all three hold: `snp_id` differs from the parameter OWN_ID, `snoop_en` is 1, and `cache_mode` bit 0 is 1. Otherwise the line keeps hitting.
- R7: A locked line is never chosen as a victim and stays valid across misses to its set. When every way of a set is locked, a load miss is served without allocation: way 0, `cpu_fmiss` = 1.
- R8: `cpu_status` encodes the access as 00 load hit, 01 load miss, 10 store hit, 11 store miss. `cpu_way` gives the hitting or filled way, and is 0 on a store miss.
- R9: The diagnostic address is laid out as way (bit 8), then set index (bits 7:4), then word (bits 3:2), then two zero bits (not carried on the port). A diagnostic write sets a line's tag, valid bit and lock bit. A diagnostic read returns them.
- R10: A flush pulse clears every valid bit and leaves lock bits unchanged.
- R11: Each set holds a round-robin pointer, starting at way 0 after reset. An allocation fills the first unlocked way at or after the pointer. The pointer then moves to the way after the filled one.
- R12: `cpu_ready` is a one-cycle pulse, and `cpu_req` is held until it is seen. `cpu_ready` follows one cycle after acceptance for a load hit, and after the last memory handshake otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_mode | input | 2 | Cache state field (R3) |
| snoop_en | input | 1 | Snoop invalidation enable |
| flush_req | input | 1 | One-cycle pulse that drops all lines |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Load data |
| cpu_status | output | 2 | Access status code |
| cpu_way | output | WAY_W | Way that hit or was filled |
| cpu_bypass | output | 1 | Access bypassed a disabled cache |
| cpu_fmiss | output | 1 | Load miss that was not allocated |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle handshake per word |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| snp_valid | input | 1 | Snooped write present |
| snp_id | input | ID_W | Master that wrote |
| snp_addr | input | ADDR_W-OFF_W | Line address of the snooped write |
| diag_req | input | 1 | Diagnostic request, held until `diag_ack` |
| diag_we | input | 1 | Diagnostic tag write |
| diag_addr | input | DIAG_W-BYTE_W | Diagnostic way/index/word (bits DIAG_W-1:BYTE_W) |
| diag_wtag | input | TAG_W | Tag to write |
| diag_wvalid | input | 1 | Valid bit to write |
| diag_wlock | input | 1 | Lock bit to write |
| diag_ack | output | 1 | Diagnostic completion pulse |
| diag_rtag | output | TAG_W | Tag read |
| diag_rvalid | output | 1 | Valid bit read |
| diag_rlock | output | 1 | Lock bit read |
| diag_rdata | output | DATA_W | Data word read |

## Verification
The assertions assume a well-behaved environment on several points:
- `cpu_req` is held until `cpu_ready`.
- `mem_ack` pulses for one cycle only while `mem_req` is high.
- A snoop never names the line being filled.
- A flush never coincides with a diagnostic write.

The stimulus respects each of these:
- Its memory model acknowledges every other cycle while a request is pending.
- It raises snoop and flush pulses only between accesses.
- It issues diagnostic requests only while the processor port is quiet.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef enum logic [1:0] {
        ST_RD_HIT  = 2'b00,
        ST_RD_MISS = 2'b01,
        ST_WR_HIT  = 2'b10,
        ST_WR_MISS = 2'b11
    } acc_stat_e;

    typedef enum logic [1:0] {
        MD_OFF,
        MD_FROZEN,
        MD_ON
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SINGLE,
        S_FILL,
        S_RESP,
        S_DRESP
    } fsm_e;

    function automatic mode_e decode_mode(input logic [1:0] f);
        if (!f[0])
            return MD_OFF;
        else if (f[1])
            return MD_ON;
        else
            return MD_FROZEN;
    endfunction

endpackage

// File: rtl/dc_tag_array.sv
module dc_tag_array #(
    parameter int WAYS  = 2,
    parameter int SETS  = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            flush,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
    output logic [WAYS-1:0]                 rd_valid,
    output logic [WAYS-1:0]                 rd_lock,
    input  logic                            wr_en,
    input  logic [WAY_W-1:0]                wr_way,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                wr_tag,
    input  logic                            wr_valid,
    input  logic                            wr_lock_en,
    input  logic                            wr_lock,
    input  logic                            inv_en,
    input  logic [IDX_W-1:0]                inv_idx,
    input  logic [TAG_W-1:0]                inv_tag
);

    logic [TAG_W-1:0]           tag_q [SETS][WAYS];
    logic [SETS-1:0][WAYS-1:0]  vld_q;
    logic [SETS-1:0][WAYS-1:0]  lock_q;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w] = tag_q[rd_idx][w];
        end
        rd_valid = vld_q[rd_idx];
        rd_lock  = lock_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            lock_q <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (flush) begin
                        vld_q[s][w] <= 1'b0;
                    end else if (wr_en && wr_idx == IDX_W'(s) && wr_way == WAY_W'(w)) begin
                        tag_q[s][w] <= wr_tag;
                        vld_q[s][w] <= wr_valid;
                        if (wr_lock_en)
                            lock_q[s][w] <= wr_lock;
                    end else if (inv_en && inv_idx == IDX_W'(s) && vld_q[s][w]
                                 && tag_q[s][w] == inv_tag) begin
                        vld_q[s][w] <= 1'b0;
                    end
                end
            end
        end
    end

    // R10: a flush leaves no valid line behind
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0));

    // R7: lock bits change only through a lock-carrying write
    p_lock_held_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_lock_en) |=> $stable(lock_q));

endmodule

// File: rtl/dc_victim.sv
module dc_victim #(
    parameter int WAYS = 2,
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [WAYS-1:0]  lock,
    output logic [WAY_W-1:0] vic_way,
    output logic             vic_ok,
    input  logic             adv,
    input  logic [IDX_W-1:0] adv_idx,
    input  logic [WAY_W-1:0] adv_way
);

    logic [SETS-1:0][WAY_W-1:0] rr_q;

    always_comb begin
        vic_ok  = 1'b0;
        vic_way = '0;
        for (int k = 0; k < WAYS; k++) begin
            int c;
            c = (int'(rr_q[idx]) + k) % WAYS;
            if (!vic_ok && !lock[c]) begin
                vic_ok  = 1'b1;
                vic_way = WAY_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (adv)
            rr_q[adv_idx] <= (int'(adv_way) == WAYS - 1) ? '0 : adv_way + 1'b1;
    end

    // R7: the chosen victim is never a locked way
    p_victim_unlocked_r7: assert property (@(posedge clk) disable iff (rst)
        vic_ok |-> !lock[vic_way]);

    // R7: a fully locked set yields no victim
    p_full_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (&lock) |-> !vic_ok);

endmodule

// File: rtl/dc_data_array.sv
module dc_data_array #(
    parameter int WAYS   = 2,
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int AW    = ((WAYS > 1) ? $clog2(WAYS) : 1) + $clog2(SETS) + $clog2(WORDS),
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import dc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAYS   = 2,
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int ID_W   = 4,
    parameter int OWN_ID = 3,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int WORD_W = $clog2(WORDS),
    localparam int OFF_W  = WORD_W + BYTE_W,
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int DIAG_W = WAY_W + IDX_W + OFF_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              cache_mode,
    input  logic                    snoop_en,
    input  logic                    flush_req,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic [1:0]              cpu_status,
    output logic [WAY_W-1:0]        cpu_way,
    output logic                    cpu_bypass,
    output logic                    cpu_fmiss,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    snp_valid,
    input  logic [ID_W-1:0]         snp_id,
    input  logic [ADDR_W-1:OFF_W]   snp_addr,
    input  logic                    diag_req,
    input  logic                    diag_we,
    input  logic [DIAG_W-1:BYTE_W]  diag_addr,
    input  logic [TAG_W-1:0]        diag_wtag,
    input  logic                    diag_wvalid,
    input  logic                    diag_wlock,
    output logic                    diag_ack,
    output logic [TAG_W-1:0]        diag_rtag,
    output logic                    diag_rvalid,
    output logic                    diag_rlock,
    output logic [DATA_W-1:0]       diag_rdata
);

    localparam int DA_W = WAY_W + IDX_W + WORD_W;

    fsm_e              state_q;
    mode_e             md;
    logic              cache_on;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              req_we, alloc_q;
    logic [WAY_W-1:0]  vway_q;
    logic [WORD_W-1:0] beat_q;
    acc_stat_e         stat_q;

    logic [IDX_W-1:0]  c_idx, q_idx, d_idx, rd_idx;
    logic [TAG_W-1:0]  c_tag, q_tag;
    logic [WORD_W-1:0] c_word, d_word;
    logic [WAY_W-1:0]  d_way;

    logic [WAYS-1:0][TAG_W-1:0] t_tag;
    logic [WAYS-1:0]   t_vld, t_lock;
    logic              hit_any, vic_ok;
    logic [WAY_W-1:0]  hit_way, vic_way;

    logic              accept, dg_go, fill_last, alloc_now;
    logic              twe, tvalid, tlk_en, tlock;
    logic [WAY_W-1:0]  tway;
    logic [IDX_W-1:0]  tidx;
    logic [TAG_W-1:0]  ttag;
    logic              dwe;
    logic [DA_W-1:0]   dwaddr;
    logic [DATA_W-1:0] dwdata, hit_data, dg_data;
    logic              inv_en;

    assign md       = decode_mode(cache_mode);
    assign cache_on = (md != MD_OFF);

    assign c_idx  = cpu_addr[OFF_W +: IDX_W];
    assign c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign c_word = cpu_addr[BYTE_W +: WORD_W];
    assign q_idx  = req_addr[OFF_W +: IDX_W];
    assign q_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign d_way  = diag_addr[DIAG_W-1 -: WAY_W];
    assign d_idx  = diag_addr[OFF_W +: IDX_W];
    assign d_word = diag_addr[BYTE_W +: WORD_W];
    assign rd_idx = cpu_req ? c_idx : d_idx;

    assign accept    = (state_q == S_IDLE) && cpu_req;
    assign dg_go     = (state_q == S_IDLE) && !cpu_req && diag_req;
    assign fill_last = (state_q == S_FILL) && mem_ack && (beat_q == WORD_W'(WORDS - 1));
    assign alloc_now = accept && !cpu_we && (md == MD_ON) && !hit_any && vic_ok;

    always_comb begin
        hit_any = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (t_vld[w] && t_tag[w] == c_tag && !hit_any) begin
                hit_any = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    dc_tag_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .flush(flush_req),
        .rd_idx(rd_idx), .rd_tag(t_tag), .rd_valid(t_vld), .rd_lock(t_lock),
        .wr_en(twe), .wr_way(tway), .wr_idx(tidx), .wr_tag(ttag), .wr_valid(tvalid),
        .wr_lock_en(tlk_en), .wr_lock(tlock),
        .inv_en(inv_en), .inv_idx(snp_addr[OFF_W +: IDX_W]), .inv_tag(snp_addr[ADDR_W-1 -: TAG_W])
    );

    dc_victim #(.WAYS(WAYS), .SETS(SETS)) u_victim (
        .clk(clk), .rst(rst), .idx(c_idx), .lock(t_lock),
        .vic_way(vic_way), .vic_ok(vic_ok),
        .adv(fill_last && alloc_q), .adv_idx(q_idx), .adv_way(vway_q)
    );

    dc_data_array #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .we(dwe), .waddr(dwaddr), .wdata(dwdata),
        .raddr_a({hit_way, c_idx, c_word}), .rdata_a(hit_data),
        .raddr_b({d_way, d_idx, d_word}), .rdata_b(dg_data)
    );

    assign inv_en = snp_valid && snoop_en && cache_on && (snp_id != ID_W'(OWN_ID));

    // Tag write port: diagnostic, victim invalidation at fill start, fill completion
    always_comb begin
        twe = 1'b0; tway = vic_way; tidx = c_idx; ttag = c_tag;
        tvalid = 1'b0; tlk_en = 1'b0; tlock = 1'b0;
        if (dg_go && diag_we) begin
            twe = 1'b1; tway = d_way; tidx = d_idx; ttag = diag_wtag;
            tvalid = diag_wvalid; tlk_en = 1'b1; tlock = diag_wlock;
        end else if (alloc_now) begin
            twe = 1'b1;
        end else if (fill_last && alloc_q) begin
            twe = 1'b1; tway = vway_q; tidx = q_idx; ttag = q_tag; tvalid = 1'b1;
        end
    end

    always_comb begin
        dwe = 1'b0;
        dwaddr = {vway_q, q_idx, beat_q};
        dwdata = mem_rdata;
        if (accept && cache_on && cpu_we && hit_any) begin
            dwe = 1'b1;
            dwaddr = {hit_way, c_idx, c_word};
            dwdata = cpu_wdata;
        end else if ((state_q == S_FILL) && mem_ack && alloc_q) begin
            dwe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            req_addr <= '0; req_wdata <= '0; req_we <= 1'b0;
            alloc_q <= 1'b0; vway_q <= '0; beat_q <= '0;
            stat_q <= ST_RD_HIT; cpu_way <= '0; cpu_rdata <= '0;
            cpu_bypass <= 1'b0; cpu_fmiss <= 1'b0;
            diag_rtag <= '0; diag_rvalid <= 1'b0; diag_rlock <= 1'b0; diag_rdata <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (cpu_req) begin
                        req_addr <= cpu_addr; req_wdata <= cpu_wdata; req_we <= cpu_we;
                        cpu_bypass <= !cache_on;
                        cpu_fmiss <= 1'b0;
                        cpu_way <= '0;
                        beat_q <= '0;
                        if (!cache_on) begin
                            stat_q <= cpu_we ? ST_WR_MISS : ST_RD_MISS;
                            state_q <= S_SINGLE;
                        end else if (cpu_we) begin
                            stat_q <= hit_any ? ST_WR_HIT : ST_WR_MISS;
                            if (hit_any) cpu_way <= hit_way;
                            state_q <= S_SINGLE;
                        end else if (hit_any) begin
                            stat_q <= ST_RD_HIT;
                            cpu_way <= hit_way;
                            cpu_rdata <= hit_data;
                            state_q <= S_RESP;
                        end else begin
                            stat_q <= ST_RD_MISS;
                            alloc_q <= alloc_now;
                            vway_q <= vic_way;
                            if (alloc_now) cpu_way <= vic_way;
                            cpu_fmiss <= !alloc_now;
                            state_q <= S_FILL;
                        end
                    end else if (diag_req) begin
                        diag_rtag <= t_tag[d_way];
                        diag_rvalid <= t_vld[d_way];
                        diag_rlock <= t_lock[d_way];
                        diag_rdata <= dg_data;
                        state_q <= S_DRESP;
                    end
                end
                S_SINGLE: if (mem_ack) begin
                    cpu_rdata <= mem_rdata;
                    state_q <= S_RESP;
                end
                S_FILL: if (mem_ack) begin
                    if (beat_q == req_addr[BYTE_W +: WORD_W]) cpu_rdata <= mem_rdata;
                    beat_q <= beat_q + 1'b1;
                    if (fill_last) state_q <= S_RESP;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign cpu_ready  = (state_q == S_RESP);
    assign diag_ack   = (state_q == S_DRESP);
    assign cpu_status = stat_q;
    assign mem_req    = (state_q == S_SINGLE) || (state_q == S_FILL);
    assign mem_we     = (state_q == S_SINGLE) && req_we;
    assign mem_wdata  = req_wdata;
    assign mem_addr   = (state_q == S_FILL)
                      ? {req_addr[ADDR_W-1:OFF_W], beat_q, BYTE_W'(0)} : req_addr;

    // R12: the completion strobe lasts one cycle
    p_ready_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R1: an accepted store reaches memory as a write next cycle
    p_store_through_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_we) |=> (mem_req && mem_we));

    // R8: a store miss reports way 0
    p_wmiss_way_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_status == ST_WR_MISS) |-> (cpu_way == '0));

    // R5: a bypassed access reports a miss code on way 0
    p_bypass_code_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_bypass) |-> (cpu_status[0] && cpu_way == '0));

    // R4: the non-allocated flag comes only with a load miss
    p_fmiss_code_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_fmiss) |-> (cpu_status == ST_RD_MISS));

endmodule

// File: tb/wt_dcache_bench.sv
`timescale 1ns/1ps
module wt_dcache_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0]  cache_mode = 2'b11;
    logic        snoop_en = 1'b0, flush_req = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_bypass, cpu_fmiss;
    logic [31:0] cpu_rdata;
    logic [1:0]  cpu_status;
    logic [0:0]  cpu_way;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [3:0]  snp_id = '0;
    logic [31:4] snp_addr = '0;
    logic        diag_req = 1'b0, diag_we = 1'b0, diag_wvalid = 1'b0, diag_wlock = 1'b0;
    logic [8:2]  diag_addr = '0;
    logic [23:0] diag_wtag = '0;
    logic        diag_ack, diag_rvalid, diag_rlock;
    logic [23:0] diag_rtag;
    logic [31:0] diag_rdata;

    wt_dcache u_wt_dcache (
        .clk(clk), .rst(rst), .cache_mode(cache_mode), .snoop_en(snoop_en), .flush_req(flush_req),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_status(cpu_status), .cpu_way(cpu_way),
        .cpu_bypass(cpu_bypass), .cpu_fmiss(cpu_fmiss),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .snp_valid(snp_valid), .snp_id(snp_id), .snp_addr(snp_addr),
        .diag_req(diag_req), .diag_we(diag_we), .diag_addr(diag_addr), .diag_wtag(diag_wtag),
        .diag_wvalid(diag_wvalid), .diag_wlock(diag_wlock), .diag_ack(diag_ack),
        .diag_rtag(diag_rtag), .diag_rvalid(diag_rvalid), .diag_rlock(diag_rlock),
        .diag_rdata(diag_rdata)
    );

    // memory model: one word per handshake, ack every other cycle
    logic [31:0] mem [1024];
    int          rd_cnt = 0, wr_cnt = 0;
    int          rlog [8];
    initial for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 + i;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we) begin
                mem[mem_addr[11:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rlog[rd_cnt % 8] <= int'(mem_addr);
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  st;
        logic        way;
        logic        byp;
        logic        fm;
        logic        chkd;
        logic [31:0] data;
    } exp_t;

    exp_t  eq [$];
    string tq [$];

    // monitor: pop the expected item for each completion
    always @(negedge clk) begin
        if (!rst && cpu_ready) begin
            if (eq.size() == 0) begin
                chk("R12 unexpected ready", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = eq.pop_front();
                t = tq.pop_front();
                chk({t, " R8 status"}, cpu_status, e.st);
                chk({t, " R8 way"}, cpu_way, e.way);
                chk({t, " R5 bypass"}, cpu_bypass, e.byp);
                chk({t, " R4 fmiss"}, cpu_fmiss, e.fm);
                if (e.chkd) chk({t, " data"}, cpu_rdata, e.data);
            end
        end
    end

    // driver: push the expectation, run the access, check memory traffic
    task automatic op(bit we, int a, logic [31:0] d, logic [1:0] st, bit way,
                      bit byp, bit fm, int nbeats, string tag);
        exp_t e;
        int   r0, w0;
        e.st = st; e.way = way; e.byp = byp; e.fm = fm; e.chkd = !we;
        e.data = mem[a[11:2]];
        eq.push_back(e);
        tq.push_back(tag);
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do @(negedge clk); while (!cpu_ready);
        cpu_req = 1'b0;
        if (we) begin
            chk({tag, " R1 one write"}, wr_cnt - w0, 1);
            chk({tag, " R1 memory data"}, mem[a[11:2]], d);
        end else begin
            chk({tag, " R2 read beats"}, rd_cnt - r0, nbeats);
            if (nbeats > 0)
                chk({tag, " R2 first address"}, rlog[r0 % 8], (nbeats == 4) ? (a & ~15) : a);
        end
    endtask

    task automatic rd(int a, logic [1:0] st, bit way, bit byp, bit fm, int nb, string tag);
        op(1'b0, a, '0, st, way, byp, fm, nb, tag);
    endtask

    task automatic wr(int a, logic [31:0] d, logic [1:0] st, bit way, bit byp, string tag);
        op(1'b1, a, d, st, way, byp, 1'b0, 0, tag);
    endtask

    task automatic dg(bit we, int way, int idx, int tag, bit v, bit lk,
                      output logic [23:0] rt, output logic rv, output logic rl);
        int a;
        a = (way << 8) | (idx << 4);
        @(negedge clk);
        diag_req = 1'b1; diag_we = we; diag_addr = a[8:2];
        diag_wtag = tag[23:0]; diag_wvalid = v; diag_wlock = lk;
        do @(negedge clk); while (!diag_ack);
        rt = diag_rtag; rv = diag_rvalid; rl = diag_rlock;
        diag_req = 1'b0; diag_we = 1'b0;
    endtask

    task automatic snoop(int id, int a);
        @(negedge clk);
        snp_valid = 1'b1; snp_id = id[3:0]; snp_addr = a[31:4];
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R12 actual=hung expected=complete");
        finish_run();
    end

    initial begin
        logic [23:0] rt;
        logic        rv, rl;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk("reset R12 ready", cpu_ready, 0);
        chk("reset R2 mem_req", mem_req, 0);
        chk("reset R9 diag_ack", diag_ack, 0);

        // enabled (R3): fills, hits and round-robin (R11)
        cache_mode = 2'b11;
        rd(32'h004, 2'b01, 0, 0, 0, 4, "R2 miss fill way0");
        rd(32'h008, 2'b00, 0, 0, 0, 0, "R2 hit way0");
        rd(32'h104, 2'b01, 1, 0, 0, 4, "R11 second fill way1");
        rd(32'h104, 2'b00, 1, 0, 0, 0, "R2 hit way1");
        wr(32'h008, 32'h1111_2222, 2'b10, 0, 0, "R1 store hit");
        rd(32'h008, 2'b00, 0, 0, 0, 0, "R1 hit sees stored word");
        wr(32'h304, 32'h3333_4444, 2'b11, 0, 0, "R1 store miss");
        rd(32'h304, 2'b01, 0, 0, 0, 4, "R1 no allocate then fill way0");
        rd(32'h004, 2'b01, 1, 0, 0, 4, "R11 evicted line refills way1");

        // locks (R7, R9)
        dg(1'b1, 0, 0, 3, 1'b1, 1'b1, rt, rv, rl);
        dg(1'b0, 0, 0, 0, 1'b0, 1'b0, rt, rv, rl);
        chk("R9 diag tag", rt, 3);
        chk("R9 diag valid", rv, 1);
        chk("R9 diag lock", rl, 1);
        rd(32'h204, 2'b01, 1, 0, 0, 4, "R7 locked way0 skipped");
        rd(32'h404, 2'b01, 1, 0, 0, 4, "R7 locked way0 skipped again");
        rd(32'h304, 2'b00, 0, 0, 0, 0, "R7 locked line stays");
        dg(1'b1, 1, 0, 4, 1'b1, 1'b1, rt, rv, rl);
        rd(32'h504, 2'b01, 0, 0, 1, 4, "R7 all locked no allocate");
        rd(32'h504, 2'b01, 0, 0, 1, 4, "R7 still not cached");
        rd(32'h404, 2'b00, 1, 0, 0, 0, "R7 locked way1 hit");

        // frozen (R3, R4)
        cache_mode = 2'b01;
        rd(32'h014, 2'b01, 0, 0, 1, 4, "R4 frozen miss");
        rd(32'h014, 2'b01, 0, 0, 1, 4, "R4 frozen miss not allocated");
        rd(32'h304, 2'b00, 0, 0, 0, 0, "R4 frozen hit");
        wr(32'h304, 32'h5555_6666, 2'b10, 0, 0, "R4 frozen store hit");
        rd(32'h304, 2'b00, 0, 0, 0, 0, "R4 frozen hit sees store");

        // disabled (R3, R5)
        cache_mode = 2'b00;
        rd(32'h304, 2'b01, 0, 1, 0, 1, "R5 bypass load");
        wr(32'h024, 32'h7777_8888, 2'b11, 0, 1, "R5 bypass store");
        cache_mode = 2'b10;
        rd(32'h008, 2'b01, 0, 1, 0, 1, "R3 mode 10 disabled");

        // snooping (R6)
        cache_mode = 2'b11;
        rd(32'h024, 2'b01, 0, 0, 0, 4, "R6 fill before snoop");
        snoop(3, 32'h024);
        rd(32'h024, 2'b00, 0, 0, 0, 0, "R6 own id ignored");
        snoop(5, 32'h024);
        rd(32'h024, 2'b00, 0, 0, 0, 0, "R6 snoop disabled ignored");
        snoop_en = 1'b1;
        snoop(5, 32'h024);
        rd(32'h024, 2'b01, 1, 0, 0, 4, "R6 foreign snoop invalidates");

        // flush (R10)
        @(negedge clk) flush_req = 1'b1;
        @(negedge clk) flush_req = 1'b0;
        rd(32'h024, 2'b01, 0, 0, 0, 4, "R10 miss after flush");
        dg(1'b0, 0, 0, 0, 1'b0, 1'b0, rt, rv, rl);
        chk("R10 valid cleared", rv, 0);
        chk("R10 lock kept", rl, 1);
        rd(32'h304, 2'b01, 0, 0, 1, 4, "R10 R7 locked set after flush");

        repeat (4) @(negedge clk);
        chk("R12 queue drained", eq.size(), 0);
        finish_run();
    end

endmodule